// File: doc/BRIEF.md
# Disturb-Driven Flash Page Fingerprint Extractor

This block derives a physical fingerprint for one flash page by stressing a neighbouring page and watching when each bit of the observed page gives way. After a start pulse it erases the selected block, so the observed (victim) page begins as all ones. It then repeatedly stresses the aggressor page, the page given in the configuration, and reads the victim page, which is always the next page address (aggressor + 1, wrapping). For every victim bit it keeps the stress index at which that bit was first seen as 0. That index is frozen once it has been taken.

Two stress modes exist. In program-stress mode each step programs the aggressor once and then reads the victim, and the recorded value is the number of programs so far. In read-stress mode each step reads the aggressor, and the victim is read only after every `SAMPLE_EVERY`-th aggressor read. The recorded value is then the sample number. Each mode has its own cap. A run also ends early once every victim bit has flipped. A bit that never flips is reported as 0. At the end the block streams one count per bit, in ascending bit order, one per cycle. Because each fingerprint belongs to one aggressor/victim pair, a device yields many independent fingerprints.

Controller states and transitions: `ST_IDLE` goes to `ST_ERASE` on start. `ST_ERASE` goes to `ST_STRESS` when the flash completes. `ST_STRESS` goes to `ST_SAMPLE` on completion (program-stress mode, or read-stress mode when the sampling period is reached). Otherwise it stays in `ST_STRESS`. `ST_SAMPLE` goes to `ST_EVAL` on completion. `ST_EVAL` goes to `ST_DUMP` when all bits have flipped or the cap is reached, and returns to `ST_STRESS` otherwise. `ST_DUMP` goes to `ST_IDLE` after the last element.

Top module: `fpx_extract`

## Requirements
- R1: After reset `busy`, `cmd_valid` and `out_valid` are 0.
- R2: A start pulse seen while idle latches mode, block and page. The first command of the run is an erase (`cmd_op` 0) of the latched block. A start pulse while `busy` is 1 is ignored.
- R3: In program-stress mode each step is a program (`cmd_op` 1) of the aggressor page followed by a read (`cmd_op` 2) of the victim page, aggressor page + 1.
- R4: In program-stress mode a bit's count is the number of programs completed when it was first read as 0. Later reads, including ones that show the bit as 1 again, do not change it.
- R5: Program-stress mode issues at most `PROG_CAP` programs. A bit still 1 after that is reported as 0.
- R6: A run ends after the first victim read in which every bit has been recorded as flipped, with no further stress commands.
- R7: In read-stress mode the aggressor page is read (`cmd_op` 2) repeatedly. The victim is read after every `SAMPLE_EVERY`-th aggressor read, and a bit's count is the 1-based number of the victim sample that first showed it as 0.
- R8: Read-stress mode issues at most `READ_CAP / SAMPLE_EVERY` samples, that is, that many periods of `SAMPLE_EVERY` aggressor reads. A bit not flipped by then is reported as 0.
- R9: At the end of a run `out_valid` is 1 for exactly `PAGE_BITS` consecutive cycles with `out_index` 0, 1, … and `out_last` on the final one, with no command issued. `busy` is 0 in the cycle after `out_last`.
- R10: A command stays asserted with unchanged opcode and address until `cmd_done`, and only one command is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| cfg_mode | input | 1 | 0 program-stress, 1 read-stress |
| cfg_block | input | BLK_W | Block to erase and stress |
| cfg_page | input | PG_W | Aggressor page; victim is the next page |
| busy | output | 1 | Run in progress, including the dump |
| cmd_valid | output | 1 | Flash command request |
| cmd_op | output | 2 | 0 erase, 1 program, 2 read |
| cmd_block | output | BLK_W | Command block address |
| cmd_page | output | PG_W | Command page address |
| cmd_done | input | 1 | Flash completes the current command (one-cycle pulse) |
| rd_data | input | PAGE_BITS | Read data, valid with `cmd_done` of a read |
| out_valid | output | 1 | Fingerprint element valid |
| out_last | output | 1 | Final element of the dump |
| out_index | output | IDX_W | Bit position of the element |
| out_count | output | CNT_W | First-flip index, 0 if never flipped |

## Verification
The bound checker checks these on every cycle:
- commands stay stable until completion;
- a run opens with an erase;
- every read that follows a program targets the adjacent page;
- the number of programs never goes past the cap;
- the dump runs in strict index order, issues no command, and ends the run.

The values of the first-flip indices can only be shown by the bench's scenarios. Those scenarios use a flash model with per-bit thresholds, and they cover the early stop, the two caps, the rounding of read-stress samples and the freezing of a count when a bit later reads as 1 again.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    typedef enum logic [1:0] {
        OP_ERASE = 2'd0,
        OP_PROG  = 2'd1,
        OP_READ  = 2'd2
    } flash_op_e;

    typedef enum logic {
        MODE_PROG = 1'b0,
        MODE_READ = 1'b1
    } stress_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ERASE  = 3'd1,
        ST_STRESS = 3'd2,
        ST_SAMPLE = 3'd3,
        ST_EVAL   = 3'd4,
        ST_DUMP   = 3'd5
    } fpx_state_e;

endpackage

// File: rtl/fpx_ctrl.sv
module fpx_ctrl
    import fpx_pkg::*;
#(
    parameter int BLK_W        = 10,
    parameter int PG_W         = 8,
    parameter int CNT_W        = 14,
    parameter int PROG_CAP     = 10000,
    parameter int READ_SAMPLES = 10000,
    parameter int SAMPLE_EVERY = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cfg_mode,
    input  logic [BLK_W-1:0] cfg_block,
    input  logic [PG_W-1:0]  cfg_page,
    input  logic             cmd_done,
    input  logic             all_flipped,
    input  logic             dump_last,
    output logic             busy,
    output logic             cmd_valid,
    output logic [1:0]       cmd_op,
    output logic [BLK_W-1:0] cmd_block,
    output logic [PG_W-1:0]  cmd_page,
    output logic             clear,
    output logic             cap_en,
    output logic             dump_en,
    output logic [CNT_W-1:0] iter
);

    localparam int SUB_W = $clog2(SAMPLE_EVERY + 1);
    localparam logic [SUB_W-1:0] SUB_LAST   = SUB_W'(SAMPLE_EVERY - 1);
    localparam logic [CNT_W-1:0] PROG_LIMIT = CNT_W'(PROG_CAP);
    localparam logic [CNT_W-1:0] READ_LIMIT = CNT_W'(READ_SAMPLES);

    fpx_state_e   state, state_nx;
    stress_mode_e mode_q;
    logic [BLK_W-1:0] blk_q;
    logic [PG_W-1:0]  pg_q;
    logic [SUB_W-1:0] sub_q;
    logic             stress_done;
    logic             period_end;
    logic             at_cap;

    assign stress_done = (state == ST_STRESS) && cmd_done;
    assign period_end  = (mode_q == MODE_PROG) || (sub_q == SUB_LAST);
    assign at_cap      = (mode_q == MODE_PROG) ? (iter == PROG_LIMIT)
                                               : (iter == READ_LIMIT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // run context and stress counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_PROG;
            blk_q  <= '0;
            pg_q   <= '0;
            iter   <= '0;
            sub_q  <= '0;
        end else if ((state == ST_IDLE) && start) begin
            mode_q <= stress_mode_e'(cfg_mode);
            blk_q  <= cfg_block;
            pg_q   <= cfg_page;
            iter   <= '0;
            sub_q  <= '0;
        end else if (stress_done) begin
            if (period_end) begin
                sub_q <= '0;
                iter  <= iter + CNT_W'(1);
            end else begin
                sub_q <= sub_q + SUB_W'(1);
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_ERASE;
            ST_ERASE:  if (cmd_done) state_nx = ST_STRESS;
            ST_STRESS: if (cmd_done && period_end) state_nx = ST_SAMPLE;
            ST_SAMPLE: if (cmd_done) state_nx = ST_EVAL;
            ST_EVAL:   state_nx = (all_flipped || at_cap) ? ST_DUMP : ST_STRESS;
            ST_DUMP:   if (dump_last) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        flash_op_e op;
        op        = OP_READ;
        cmd_valid = 1'b0;
        cmd_page  = pg_q;
        cmd_block = blk_q;
        clear     = 1'b0;
        cap_en    = 1'b0;
        dump_en   = 1'b0;
        busy      = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy  = 1'b0;
                clear = start;
            end
            ST_ERASE: begin
                cmd_valid = 1'b1;
                op        = OP_ERASE;
            end
            ST_STRESS: begin
                cmd_valid = 1'b1;
                op        = (mode_q == MODE_PROG) ? OP_PROG : OP_READ;
            end
            ST_SAMPLE: begin
                cmd_valid = 1'b1;
                op        = OP_READ;
                cmd_page  = pg_q + PG_W'(1);
                cap_en    = cmd_done;
            end
            ST_EVAL: begin
            end
            ST_DUMP: begin
                dump_en = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
        cmd_op = op;
    end

endmodule

// File: rtl/fpx_capture.sv
module fpx_capture #(
    parameter int PAGE_BITS = 64,
    parameter int CNT_W     = 14,
    parameter int IDX_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 cap_en,
    input  logic [PAGE_BITS-1:0] sample,
    input  logic [CNT_W-1:0]     index,
    input  logic [IDX_W-1:0]     rd_sel,
    output logic                 all_flipped,
    output logic [CNT_W-1:0]     rd_count
);

    logic [PAGE_BITS-1:0] flipped;
    logic [CNT_W-1:0]     counts [PAGE_BITS];

    for (genvar g = 0; g < PAGE_BITS; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                flipped[g] <= 1'b0;
                counts[g]  <= '0;
            end else if (cap_en && !flipped[g] && !sample[g]) begin
                flipped[g] <= 1'b1;
                counts[g]  <= index;
            end
        end
    end

    assign all_flipped = &flipped;
    assign rd_count    = counts[rd_sel];

endmodule

// File: rtl/fpx_stream.sv
module fpx_stream #(
    parameter int PAGE_BITS = 64,
    parameter int IDX_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dump_en,
    output logic [IDX_W-1:0] idx,
    output logic             valid,
    output logic             last
);

    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(PAGE_BITS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n || !dump_en) idx <= '0;
        else                    idx <= idx + IDX_W'(1);
    end

    assign valid = dump_en;
    assign last  = dump_en && (idx == IDX_END);

endmodule

// File: rtl/fpx_extract.sv
module fpx_extract #(
    parameter int PAGE_BITS    = 64,
    parameter int BLK_W        = 10,
    parameter int PG_W         = 8,
    parameter int PROG_CAP     = 10000,
    parameter int READ_CAP     = 10000000,
    parameter int SAMPLE_EVERY = 1000,
    localparam int READ_SAMPLES = READ_CAP / SAMPLE_EVERY,
    localparam int MAX_INDEX    = (PROG_CAP > READ_SAMPLES) ? PROG_CAP : READ_SAMPLES,
    localparam int CNT_W        = $clog2(MAX_INDEX + 1),
    localparam int IDX_W        = $clog2(PAGE_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 cfg_mode,
    input  logic [BLK_W-1:0]     cfg_block,
    input  logic [PG_W-1:0]      cfg_page,
    output logic                 busy,
    output logic                 cmd_valid,
    output logic [1:0]           cmd_op,
    output logic [BLK_W-1:0]     cmd_block,
    output logic [PG_W-1:0]      cmd_page,
    input  logic                 cmd_done,
    input  logic [PAGE_BITS-1:0] rd_data,
    output logic                 out_valid,
    output logic                 out_last,
    output logic [IDX_W-1:0]     out_index,
    output logic [CNT_W-1:0]     out_count
);

    logic             clear, cap_en, dump_en, all_flipped;
    logic [CNT_W-1:0] iter;

    fpx_ctrl #(
        .BLK_W(BLK_W), .PG_W(PG_W), .CNT_W(CNT_W),
        .PROG_CAP(PROG_CAP), .READ_SAMPLES(READ_SAMPLES),
        .SAMPLE_EVERY(SAMPLE_EVERY)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
        .cfg_block(cfg_block), .cfg_page(cfg_page), .cmd_done(cmd_done),
        .all_flipped(all_flipped), .dump_last(out_last), .busy(busy),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_block(cmd_block),
        .cmd_page(cmd_page), .clear(clear), .cap_en(cap_en),
        .dump_en(dump_en), .iter(iter)
    );

    fpx_capture #(
        .PAGE_BITS(PAGE_BITS), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_capture (
        .clk(clk), .rst_n(rst_n), .clear(clear), .cap_en(cap_en),
        .sample(rd_data), .index(iter), .rd_sel(out_index),
        .all_flipped(all_flipped), .rd_count(out_count)
    );

    fpx_stream #(
        .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)
    ) u_stream (
        .clk(clk), .rst_n(rst_n), .dump_en(dump_en),
        .idx(out_index), .valid(out_valid), .last(out_last)
    );

endmodule

// File: rtl/fpx_extract_chk.sv
module fpx_extract_chk #(
    parameter int BLK_W     = 10,
    parameter int PG_W      = 8,
    parameter int PROG_CAP  = 10000,
    parameter int CNT_W     = 14,
    parameter int IDX_W     = 6,
    parameter int MAX_INDEX = 10000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic [BLK_W-1:0] cmd_block,
    input logic [PG_W-1:0]  cmd_page,
    input logic             cmd_done,
    input logic             out_valid,
    input logic             out_last,
    input logic [IDX_W-1:0] out_index,
    input logic [CNT_W-1:0] out_count
);

    int unsigned     prog_seen;
    logic            after_prog;
    logic [PG_W-1:0] last_prog_pg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_seen    <= 0;
            after_prog   <= 1'b0;
            last_prog_pg <= '0;
        end else if (cmd_valid && cmd_done) begin
            if (cmd_op == 2'd0) begin
                prog_seen  <= 0;
                after_prog <= 1'b0;
            end else if (cmd_op == 2'd1) begin
                prog_seen    <= prog_seen + 1;
                after_prog   <= 1'b1;
                last_prog_pg <= cmd_page;
            end else begin
                after_prog <= 1'b0;
            end
        end
    end

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_op) && $stable(cmd_page) && $stable(cmd_block)); // R10
    AST_ERASE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> cmd_valid && (cmd_op == 2'd0)); // R2
    AST_VICTIM_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_op == 2'd2) && after_prog |-> cmd_page == last_prog_pg + PG_W'(1)); // R3
    AST_PROG_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_op == 2'd1) |-> prog_seen < PROG_CAP); // R5
    AST_DUMP_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_last |=> out_valid && (out_index == $past(out_index) + IDX_W'(1))); // R9
    AST_DUMP_END: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |=> !busy); // R9
    AST_DUMP_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !cmd_valid); // R9
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_count <= CNT_W'(MAX_INDEX)); // R4

endmodule

bind fpx_extract fpx_extract_chk #(
    .BLK_W(BLK_W), .PG_W(PG_W), .PROG_CAP(PROG_CAP),
    .CNT_W(CNT_W), .IDX_W(IDX_W), .MAX_INDEX(MAX_INDEX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_block(cmd_block), .cmd_page(cmd_page),
    .cmd_done(cmd_done), .out_valid(out_valid), .out_last(out_last),
    .out_index(out_index), .out_count(out_count)
);

// File: tb/fpx_extract_bench.sv
`timescale 1ns/1ps
module fpx_extract_bench;

    localparam int NB    = 8;
    localparam int BW    = 4;
    localparam int PW    = 4;
    localparam int PCAP  = 20;
    localparam int RCAP  = 60;
    localparam int EVERY = 4;
    localparam int RS    = RCAP / EVERY;
    localparam int CW    = 5;
    localparam int IW    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          cfg_mode = 1'b0;
    logic [BW-1:0] cfg_block = '0;
    logic [PW-1:0] cfg_page = '0;
    logic          busy, cmd_valid, out_valid, out_last;
    logic [1:0]    cmd_op;
    logic [BW-1:0] cmd_block;
    logic [PW-1:0] cmd_page;
    logic          cmd_done = 1'b0;
    logic [NB-1:0] rd_data = '1;
    logic [IW-1:0] out_index;
    logic [CW-1:0] out_count;

    always #4 clk = ~clk;

    fpx_extract #(
        .PAGE_BITS(NB), .BLK_W(BW), .PG_W(PW),
        .PROG_CAP(PCAP), .READ_CAP(RCAP), .SAMPLE_EVERY(EVERY)
    ) u_fpx_extract (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
        .cfg_block(cfg_block), .cfg_page(cfg_page), .busy(busy),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_block(cmd_block),
        .cmd_page(cmd_page), .cmd_done(cmd_done), .rd_data(rd_data),
        .out_valid(out_valid), .out_last(out_last), .out_index(out_index),
        .out_count(out_count)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int thr_p [NB];
    int thr_r [NB];
    bit flick [NB];
    int n_prog, n_aread, n_erase, n_bad_addr, n_cmds;
    int first_op;
    int agg_pg, agg_blk;
    int got [NB];
    int n_out;
    bit order_bad;

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // flash model: latency 2, per-bit disturb thresholds
    initial begin
        bit pend = 0;
        int lat = 0;
        logic [1:0] op_q = '0;
        int pg_q = 0;
        int blk_q = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                pend = 0; cmd_done = 1'b0;
            end else if (cmd_done) begin
                cmd_done = 1'b0;
            end else if (!pend && cmd_valid) begin
                pend = 1; lat = 2; op_q = cmd_op;
                pg_q = int'(cmd_page); blk_q = int'(cmd_block);
                n_cmds++;
                if (n_cmds == 1) first_op = int'(cmd_op);
            end else if (pend) begin
                lat--;
                if (lat == 0) begin
                    pend = 0;
                    cmd_done = 1'b1;
                    if (op_q == 2'd0) begin
                        n_erase++; n_prog = 0; n_aread = 0;
                        agg_pg = pg_q; agg_blk = blk_q;
                    end else if (op_q == 2'd1) begin
                        n_prog++;
                        if (pg_q != agg_pg || blk_q != agg_blk) n_bad_addr++;
                    end else if (pg_q == agg_pg) begin
                        n_aread++;
                    end else begin
                        if (pg_q != ((agg_pg + 1) % (1 << PW)) || blk_q != agg_blk) n_bad_addr++;
                        for (int i = 0; i < NB; i++) begin
                            bit fp, fr;
                            fp = (thr_p[i] != 0) && (flick[i] ? (n_prog == thr_p[i]) : (n_prog >= thr_p[i]));
                            fr = (thr_r[i] != 0) && (n_aread >= thr_r[i]);
                            rd_data[i] = !(fp || fr);
                        end
                    end
                end
            end
        end
    end

    // dump collector
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (int'(out_index) != n_out) order_bad = 1;
                if (out_last != (n_out == NB - 1)) order_bad = 1;
                if (n_out < NB) got[n_out] = int'(out_count);
                n_out++;
            end
        end
    end

    function automatic int exp_p(input int t);
        return (t != 0 && t <= PCAP) ? t : 0;
    endfunction

    function automatic int exp_r(input int t);
        int s;
        s = (t + EVERY - 1) / EVERY;
        return (t != 0 && s <= RS) ? s : 0;
    endfunction

    task automatic run_case(input bit mode, input int blk, input int pg, input bit poke);
        int mx;
        bit all_in;
        n_prog = 0; n_aread = 0; n_erase = 0; n_bad_addr = 0; n_cmds = 0;
        n_out = 0; order_bad = 0; first_op = -1;
        @(negedge clk);
        start = 1'b1; cfg_mode = mode;
        cfg_block = BW'(blk); cfg_page = PW'(pg);
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (15) @(negedge clk);
            start = 1'b1; cfg_mode = !mode; cfg_page = PW'(pg + 5);
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        check("R2 first command is erase", first_op, 0);
        check("R2 single erase", n_erase, 1);
        check("R3 command addresses", n_bad_addr, 0);
        check("R9 dump length", n_out, NB);
        check("R9 dump order", int'(order_bad), 0);
        mx = 0; all_in = 1;
        for (int i = 0; i < NB; i++) begin
            if (mode == 1'b0) begin
                check($sformatf("R4/R5 bit %0d count", i), got[i], exp_p(thr_p[i]));
                if (exp_p(thr_p[i]) == 0) all_in = 0;
                else if (thr_p[i] > mx) mx = thr_p[i];
            end else begin
                check($sformatf("R7/R8 bit %0d count", i), got[i], exp_r(thr_r[i]));
                if (exp_r(thr_r[i]) == 0) all_in = 0;
                else if (exp_r(thr_r[i]) > mx) mx = exp_r(thr_r[i]);
            end
        end
        if (mode == 1'b0) begin
            check("R5/R6 programs issued", n_prog, all_in ? mx : PCAP);
            check("R3 no aggressor reads", n_aread, 0);
        end else begin
            check("R6/R8 aggressor reads", n_aread, all_in ? mx * EVERY : RS * EVERY);
            check("R7 no programs", n_prog, 0);
        end
    endtask

    task automatic set_p(input int a0, a1, a2, a3, a4, a5, a6, a7);
        int v [NB];
        v = '{a0, a1, a2, a3, a4, a5, a6, a7};
        for (int i = 0; i < NB; i++) begin thr_p[i] = v[i]; thr_r[i] = 0; flick[i] = 0; end
    endtask

    task automatic set_r(input int a0, a1, a2, a3, a4, a5, a6, a7);
        int v [NB];
        v = '{a0, a1, a2, a3, a4, a5, a6, a7};
        for (int i = 0; i < NB; i++) begin thr_r[i] = v[i]; thr_p[i] = 0; flick[i] = 0; end
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) begin thr_p[i] = 0; thr_r[i] = 0; flick[i] = 0; end
        repeat (3) @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 cmd_valid after reset", int'(cmd_valid), 0);
        check("R1 out_valid after reset", int'(out_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle before start", int'(busy), 0);

        // R5: program cap with never-flipping and beyond-cap bits
        set_p(1, 3, 5, 0, 20, 21, 7, 2);
        run_case(1'b0, 3, 6, 1'b0);
        // R6: early end in program-stress mode, R4 freeze with flickering bits, R2 ignored start
        set_p(2, 4, 1, 6, 3, 5, 6, 2);
        flick[0] = 1; flick[3] = 1;
        run_case(1'b0, 9, 15, 1'b1);
        // R7/R8: read-stress rounding and cap
        set_r(1, 4, 5, 8, 9, 60, 61, 0);
        run_case(1'b1, 1, 2, 1'b0);
        // R6: read-stress early end
        set_r(3, 7, 2, 12, 4, 1, 5, 8);
        run_case(1'b1, 14, 0, 1'b1);
        // sweep of threshold patterns in both modes
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < NB; i++) begin
                thr_p[i] = (i * 5 + k * 11 + 3) % 26; thr_r[i] = 0; flick[i] = 0;
            end
            run_case(1'b0, k, k * 3, 1'b0);
            for (int i = 0; i < NB; i++) begin
                thr_r[i] = (i * 9 + k * 13 + 1) % 70; thr_p[i] = 0; flick[i] = 0;
            end
            run_case(1'b1, k + 4, k * 5, 1'b0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule